// File: doc/BRIEF.md
# PATA PIO Cycle Timing Generator

This block turns single-pulse host I/O requests into programmed-I/O cycles on a parallel ATA channel. It compares each host address with the legacy command-block window (eight byte registers) and the one-byte control port of the channel chosen in its 16-bit timing configuration word. An address that matches becomes a bus cycle: a chip select, three address lines, and a read or write strobe whose active width and recovery time come from the configuration word. Read data returns with a one-clock ready pulse.

Only one set of fast timing values exists on the channel. Each drive has a control nibble in the configuration word. When a drive's fast bit is set, its cycles use the programmed sample point and recovery values. When the bit is clear, the drive gets a fixed, slow, compatible cycle. The block works out which drive is selected by watching host writes to the device/head register. When a drive has IORDY sampling enabled, it can stretch the strobe. A bounded wait stops a stuck drive from hanging the host, and a timeout sets a sticky error flag.

Top module: `pata_pio_timer`

## Requirements
- R1: While cfg_i[15] is 0, a host request starts no cycle. No chip select goes low, no strobe goes low and rdy_o stays low.
- R2: cfg_i[14]=0 selects the primary window: command bytes 0x1F0 to 0x1F7 and control port 0x3F6. cfg_i[14]=1 selects the secondary window: 0x170 to 0x177 and 0x376. Host addresses outside the selected window are ignored.
- R3: A command-block access drives ata_cs0_no low and ata_da_o = addr_i[2:0]. A control-port access drives ata_cs1_no low and ata_da_o = 6. A read uses ata_dior_no, a write uses ata_diow_no, and the two are never low together.
- R4: With the fast bit set, the strobe is low for 5−cfg_i[13:12] clocks. It is then high for 4−cfg_i[9:8] recovery clocks. rdy_o pulses for one clock in the clock after recovery ends. The strobe goes low in the clock after the one in which req_i is accepted.
- R5: With the fast bit clear, the cycle uses an 8-clock strobe and 10 clocks of recovery. The values in cfg_i[13:12] and cfg_i[9:8] have no effect, and IORDY is not sampled.
- R6: The drive nibble is cfg_i[3:0] for drive 0 and cfg_i[7:4] for drive 1. Within a nibble, bit 0 is the fast bit, bit 1 enables IORDY and bit 2 is the prefetch bit, which is stored only. A write to command offset 6 sets the selected drive to wdata_i[4]. The write itself still uses the previously selected drive's timing. Writes to the control port do not change the selection. After reset, drive 0 is selected.
- R7: When the selected drive's IORDY-enable bit is 0, a low ata_iordy_i does not lengthen the strobe.
- R8: When IORDY is enabled and ata_iordy_i is low at the end of the programmed strobe width, the strobe stays low. It rises in the clock after ata_iordy_i is seen high, and recovery follows.
- R9: An IORDY wait lasts at most 256 clocks beyond the programmed width. If it runs out, the strobe rises and err_o is set until reset. If IORDY is seen high in the last wait clock, the cycle ends normally and err_o is not set.
- R10: For a read, rdata_o holds ata_dd_i as sampled on the clock edge where the strobe rises. For a write, ata_dd_o equals wdata_i and ata_dd_oe_o is high exactly while ata_diow_no is low.
- R11: After reset, all strobes and chip selects are high, and rdy_o, err_o and ata_dd_oe_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 16 | Timing configuration word |
| req_i | input | 1 | One-clock host request pulse |
| we_i | input | 1 | Request is a write |
| addr_i | input | 10 | Host I/O address |
| wdata_i | input | 16 | Host write data |
| rdy_o | output | 1 | One-clock completion pulse |
| rdata_o | output | 16 | Read data captured from the drive |
| err_o | output | 1 | Sticky IORDY timeout flag |
| ata_cs0_no | output | 1 | Command-block chip select, active low |
| ata_cs1_no | output | 1 | Control-block chip select, active low |
| ata_da_o | output | 3 | Device address lines |
| ata_dior_no | output | 1 | Read strobe, active low |
| ata_diow_no | output | 1 | Write strobe, active low |
| ata_iordy_i | input | 1 | Drive ready |
| ata_dd_i | input | 16 | Data bus from the drive |
| ata_dd_o | output | 16 | Data bus to the drive |
| ata_dd_oe_o | output | 1 | Data bus output enable |

## Verification
Two events can land on the same clock edge. One is the IORDY wait ending because the drive releases IORDY. The other is the wait timing out on its last allowed clock. The bench holds IORDY low past the sample point and releases it on the 256th wait clock. It then expects a 261-clock strobe with err_o still clear. A second run holds IORDY low throughout and expects the same strobe length with err_o set. A second coincidence is also tested: a write to the device/head register switches the drive in the same cycle. The bench checks from the measured strobe widths that this write ran on the old drive's timing and that the next cycle ran on the new drive's timing.

// File: rtl/pata_pkg.sv
`timescale 1ns/1ps
package pata_pkg;
  localparam int CFG_EN_BIT  = 15;
  localparam int CFG_SEC_BIT = 14;
  localparam int ISP_LSB     = 12;
  localparam int RCV_LSB     = 8;
  localparam int DEVHEAD_OFS = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_WAIT = 2'd2,
    ST_REC  = 2'd3
  } cyc_st_e;

  // per-drive control nibble, msb first
  typedef struct packed {
    logic rsvd;
    logic prefetch;
    logic iordy_en;
    logic fast;
  } drv_ctl_t;
endpackage

// File: rtl/pata_addr_decode.sv
`timescale 1ns/1ps
module pata_addr_decode #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  input  logic              sec_i,
  output logic              hit_o,
  output logic              ctrl_o,
  output logic [2:0]        da_o
);
  localparam logic [ADDR_W-1:0] PRI_CMD  = ADDR_W'(10'h1F0);
  localparam logic [ADDR_W-1:0] PRI_CTRL = ADDR_W'(10'h3F6);
  localparam logic [ADDR_W-1:0] SEC_CMD  = ADDR_W'(10'h170);
  localparam logic [ADDR_W-1:0] SEC_CTRL = ADDR_W'(10'h376);

  logic [ADDR_W-1:0] cmd_base, ctrl_addr;
  logic cmd_hit, ctrl_hit;

  always_comb begin
    cmd_base  = sec_i ? SEC_CMD  : PRI_CMD;
    ctrl_addr = sec_i ? SEC_CTRL : PRI_CTRL;
    cmd_hit   = (addr_i[ADDR_W-1:3] == cmd_base[ADDR_W-1:3]);
    ctrl_hit  = (addr_i == ctrl_addr);
    hit_o     = en_i & (cmd_hit | ctrl_hit);
    ctrl_o    = ctrl_hit;
    da_o      = ctrl_hit ? 3'd6 : addr_i[2:0];
  end
endmodule

// File: rtl/pata_drive_track.sv
`timescale 1ns/1ps
module pata_drive_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic upd_i,
  input  logic sel_i,
  output logic drive_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    drive_o <= 1'b0;
    else if (upd_i) drive_o <= sel_i;
  end
endmodule

// File: rtl/pata_timing_pick.sv
`timescale 1ns/1ps
module pata_timing_pick
  import pata_pkg::*;
#(
  parameter int TCNT_W     = 4,
  parameter int COMPAT_ACT = 8,
  parameter int COMPAT_REC = 10
) (
  input  logic [15:0]       cfg_i,
  input  logic              drive_i,
  output logic [TCNT_W-1:0] act_len_o,
  output logic [TCNT_W-1:0] rec_len_o,
  output logic              iordy_en_o
);
  localparam int FAST_ACT_MAX = 5;
  localparam int FAST_REC_MAX = 4;

  drv_ctl_t nib [2];
  for (genvar g = 0; g < 2; g++) begin : g_nib
    assign nib[g] = drv_ctl_t'(cfg_i[4*g +: 4]);
  end

  drv_ctl_t   sel;
  logic [1:0] isp, rcv;
  assign sel = nib[drive_i];
  assign isp = cfg_i[ISP_LSB +: 2];
  assign rcv = cfg_i[RCV_LSB +: 2];

  always_comb begin
    if (sel.fast) begin
      act_len_o  = TCNT_W'(FAST_ACT_MAX - int'(isp));
      rec_len_o  = TCNT_W'(FAST_REC_MAX - int'(rcv));
      iordy_en_o = sel.iordy_en;
    end else begin
      act_len_o  = TCNT_W'(COMPAT_ACT);
      rec_len_o  = TCNT_W'(COMPAT_REC);
      iordy_en_o = 1'b0;
    end
  end

  logic unused_cfg;
  assign unused_cfg = ^{cfg_i[15:14], cfg_i[11:10], sel.rsvd, sel.prefetch};
endmodule

// File: rtl/pata_cycle_fsm.sv
`timescale 1ns/1ps
module pata_cycle_fsm
  import pata_pkg::*;
#(
  parameter int TCNT_W   = 4,
  parameter int TMO_CLKS = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [TCNT_W-1:0] act_len_i,
  input  logic [TCNT_W-1:0] rec_len_i,
  input  logic              iordy_en_i,
  input  logic              iordy_i,
  output logic              busy_o,
  output logic              strobe_o,
  output logic              cap_o,
  output logic              tmo_o,
  output logic              done_o
);
  localparam int WCNT_W = (TMO_CLKS > 2) ? $clog2(TMO_CLKS) : 1;
  localparam logic [WCNT_W-1:0] WLAST = WCNT_W'(TMO_CLKS - 1);

  cyc_st_e           st_q;
  logic [TCNT_W-1:0] cnt_q, act_q, rec_q;
  logic [WCNT_W-1:0] wcnt_q;
  logic              ien_q;
  logic              act_end, stretch, wait_end;

  assign act_end  = (st_q == ST_ACT) && (cnt_q == act_q);
  assign stretch  = ien_q & ~iordy_i;
  assign wait_end = (st_q == ST_WAIT) && (iordy_i || (wcnt_q == WLAST));
  assign cap_o    = (act_end & ~stretch) | wait_end;
  assign tmo_o    = (st_q == ST_WAIT) && !iordy_i && (wcnt_q == WLAST);
  assign busy_o   = (st_q != ST_IDLE);
  assign strobe_o = (st_q == ST_ACT) || (st_q == ST_WAIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      wcnt_q <= '0;
      ien_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_ACT;
          cnt_q <= TCNT_W'(1);
          act_q <= act_len_i;
          rec_q <= rec_len_i;
          ien_q <= iordy_en_i;
        end
        ST_ACT: begin
          if (act_end) begin
            if (stretch) begin
              st_q   <= ST_WAIT;
              wcnt_q <= '0;
            end else begin
              st_q  <= ST_REC;
              cnt_q <= TCNT_W'(1);
            end
          end else begin
            cnt_q <= cnt_q + TCNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (wait_end) begin
            st_q  <= ST_REC;
            cnt_q <= TCNT_W'(1);
          end else begin
            wcnt_q <= wcnt_q + WCNT_W'(1);
          end
        end
        ST_REC: begin
          if (cnt_q == rec_q) begin
            st_q   <= ST_IDLE;
            done_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + TCNT_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pata_pio_timer.sv
`timescale 1ns/1ps
module pata_pio_timer
  import pata_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int DATA_W     = 16,
  parameter int COMPAT_ACT = 8,
  parameter int COMPAT_REC = 10,
  parameter int TMO_CLKS   = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cfg_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              err_o,
  output logic              ata_cs0_no,
  output logic              ata_cs1_no,
  output logic [2:0]        ata_da_o,
  output logic              ata_dior_no,
  output logic              ata_diow_no,
  input  logic              ata_iordy_i,
  input  logic [DATA_W-1:0] ata_dd_i,
  output logic [DATA_W-1:0] ata_dd_o,
  output logic              ata_dd_oe_o
);
  localparam int LEN_MAX = (COMPAT_REC > COMPAT_ACT) ? COMPAT_REC : COMPAT_ACT;
  localparam int TCNT_W  = $clog2(((LEN_MAX > 5) ? LEN_MAX : 5) + 1);

  logic              hit, is_ctrl, drive, start, devhead_wr;
  logic [2:0]        da;
  logic [TCNT_W-1:0] act_len, rec_len;
  logic              iordy_en, busy, strobe, cap, tmo;
  logic              we_q, ctrl_q;
  logic [2:0]        da_q;
  logic [DATA_W-1:0] wdata_q;

  pata_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .en_i   (cfg_i[CFG_EN_BIT]),
    .sec_i  (cfg_i[CFG_SEC_BIT]),
    .hit_o  (hit),
    .ctrl_o (is_ctrl),
    .da_o   (da)
  );

  assign start      = req_i & hit & ~busy;
  assign devhead_wr = start & we_i & ~is_ctrl & (da == 3'(DEVHEAD_OFS));

  pata_drive_track u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (devhead_wr),
    .sel_i   (wdata_i[4]),
    .drive_o (drive)
  );

  pata_timing_pick #(
    .TCNT_W(TCNT_W), .COMPAT_ACT(COMPAT_ACT), .COMPAT_REC(COMPAT_REC)
  ) u_pick (
    .cfg_i      (cfg_i),
    .drive_i    (drive),
    .act_len_o  (act_len),
    .rec_len_o  (rec_len),
    .iordy_en_o (iordy_en)
  );

  pata_cycle_fsm #(.TCNT_W(TCNT_W), .TMO_CLKS(TMO_CLKS)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .act_len_i  (act_len),
    .rec_len_i  (rec_len),
    .iordy_en_i (iordy_en),
    .iordy_i    (ata_iordy_i),
    .busy_o     (busy),
    .strobe_o   (strobe),
    .cap_o      (cap),
    .tmo_o      (tmo),
    .done_o     (rdy_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      ctrl_q  <= 1'b0;
      da_q    <= '0;
      wdata_q <= '0;
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      if (start) begin
        we_q    <= we_i;
        ctrl_q  <= is_ctrl;
        da_q    <= da;
        wdata_q <= wdata_i;
      end
      if (cap && !we_q) rdata_o <= ata_dd_i;
      if (tmo)          err_o   <= 1'b1;
    end
  end

  assign ata_cs0_no  = ~(busy & ~ctrl_q);
  assign ata_cs1_no  = ~(busy & ctrl_q);
  assign ata_da_o    = da_q;
  assign ata_dior_no = ~(strobe & ~we_q);
  assign ata_diow_no = ~(strobe & we_q);
  assign ata_dd_o    = wdata_q;
  assign ata_dd_oe_o = strobe & we_q;
endmodule

// File: rtl/pata_pio_timer_chk.sv
`timescale 1ns/1ps
module pata_pio_timer_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       cfg_i,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rdy_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              err_o,
  input logic              ata_cs0_no,
  input logic              ata_cs1_no,
  input logic [2:0]        ata_da_o,
  input logic              ata_dior_no,
  input logic              ata_diow_no,
  input logic              ata_iordy_i,
  input logic [DATA_W-1:0] ata_dd_i,
  input logic [DATA_W-1:0] ata_dd_o,
  input logic              ata_dd_oe_o
);
  logic idle_bus;
  assign idle_bus = ata_cs0_no & ata_cs1_no & ata_dior_no & ata_diow_no;

  p_no_claim_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !cfg_i[15] && idle_bus) |=> (ata_cs0_no && ata_cs1_no));

  p_one_strobe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ata_dior_no && !ata_diow_no));

  p_one_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({~ata_cs0_no, ~ata_cs1_no}));

  p_strobe_in_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ata_dior_no || !ata_diow_no) |-> (!ata_cs0_no || !ata_cs1_no));

  p_rdy_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |=> !rdy_o);

  p_rdy_bus_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> idle_bus);

  p_err_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

  p_err_at_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> (ata_dior_no && ata_diow_no && $past(!ata_dior_no || !ata_diow_no)));

  p_oe_is_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ata_dd_oe_o == !ata_diow_no);

  logic unused_chk;
  assign unused_chk = ^{we_i, addr_i, wdata_i, rdata_o, ata_da_o, ata_iordy_i, ata_dd_i, ata_dd_o};
endmodule

bind pata_pio_timer pata_pio_timer_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_pata_pio_timer.sv
`timescale 1ns/1ps
module sim_pata_pio_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg = 16'h0000;
  logic        req = 1'b0, we = 1'b0;
  logic [9:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        rdy, err, cs0_n, cs1_n, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_out;
  logic [15:0] dd_in = 16'h0000;
  logic [2:0]  da;
  logic        iordy = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pata_pio_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_i(cfg), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdy_o(rdy), .rdata_o(rdata), .err_o(err),
    .ata_cs0_no(cs0_n), .ata_cs1_no(cs1_n), .ata_da_o(da),
    .ata_dior_no(dior_n), .ata_diow_no(diow_n), .ata_iordy_i(iordy),
    .ata_dd_i(dd_in), .ata_dd_o(dd_out), .ata_dd_oe_o(dd_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // results of the last cycle
  int          m_act, m_rec;
  logic        m_cs0n, m_cs1n, m_oe;
  logic [2:0]  m_da;
  logic [15:0] m_dd, m_rd;

  task automatic run_cyc(input logic w, input logic [9:0] a, input logic [15:0] d, input int rel);
    int guard;
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0;
    m_act = 0; m_rec = 0; guard = 0;
    m_cs0n = cs0_n; m_cs1n = cs1_n; m_da = da; m_oe = dd_oe; m_dd = dd_out;
    while (!(dior_n && diow_n) && guard < 2000) begin
      m_act++; guard++;
      if (rel > 0 && m_act == rel) iordy = 1'b1;
      @(negedge clk);
    end
    while (!rdy && guard < 2000) begin
      m_rec++; guard++;
      @(negedge clk);
    end
    m_rd = rdata;
    iordy = 1'b1;
  endtask

  task automatic idle_check(input string tag, input logic [9:0] a);
    int bad = 0;
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!(cs0_n && cs1_n && dior_n && diow_n) || rdy) bad++;
      @(negedge clk);
    end
    chk(tag, bad, 0);
  endtask

  typedef struct packed {
    logic [15:0] cfg;
    logic        we;
    logic [9:0]  addr;
    logic [15:0] wd;
    logic [7:0]  act;
    logic [7:0]  rec;
    logic        cs0n;
    logic        cs1n;
    logic [2:0]  da;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{16'hB301, 1'b0, 10'h1F0, 16'h0000, 8'd2, 8'd1,  1'b0, 1'b1, 3'd0},
    '{16'h8001, 1'b1, 10'h1F2, 16'h1234, 8'd5, 8'd4,  1'b0, 1'b1, 3'd2},
    '{16'h9201, 1'b0, 10'h1F7, 16'h0000, 8'd4, 8'd2,  1'b0, 1'b1, 3'd7},
    '{16'hB300, 1'b0, 10'h1F1, 16'h0000, 8'd8, 8'd10, 1'b0, 1'b1, 3'd1},
    '{16'hE101, 1'b1, 10'h175, 16'hBEEF, 8'd3, 8'd3,  1'b0, 1'b1, 3'd5},
    '{16'hC001, 1'b0, 10'h376, 16'h0000, 8'd5, 8'd4,  1'b1, 1'b0, 3'd6},
    '{16'h8001, 1'b1, 10'h3F6, 16'h0002, 8'd5, 8'd4,  1'b1, 1'b0, 3'd6},
    '{16'h8003, 1'b0, 10'h1F3, 16'h0000, 8'd5, 8'd4,  1'b0, 1'b1, 3'd3},
    '{16'h8005, 1'b1, 10'h1F4, 16'h5A5A, 8'd5, 8'd4,  1'b0, 1'b1, 3'd4}
  };

  task automatic timing(input string tag, input int ea, input int er);
    chk({tag, " strobe"}, m_act, ea);
    chk({tag, " recovery"}, m_rec, er);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 strobes", {dior_n, diow_n}, 2'b11);
    chk("R11 selects", {cs0_n, cs1_n}, 2'b11);
    chk("R11 rdy/err/oe", {rdy, err, dd_oe}, 3'b000);
    rst_n = 1'b1;

    // vector table: R2 R3 R4 R5 R10, drive 0 selected
    for (int i = 0; i < NV; i++) begin
      cfg = TBL[i].cfg;
      dd_in = 16'hA500 + 16'(i);
      run_cyc(TBL[i].we, TBL[i].addr, TBL[i].wd, 0);
      timing($sformatf("R4/R5 vec%0d", i), int'(TBL[i].act), int'(TBL[i].rec));
      chk($sformatf("R3 vec%0d selects", i), {m_cs0n, m_cs1n}, {TBL[i].cs1n == 1'b0 ? 1'b1 : 1'b0, TBL[i].cs1n});
      chk($sformatf("R3 vec%0d cs0", i), m_cs0n, TBL[i].cs0n);
      chk($sformatf("R3 vec%0d da", i), m_da, TBL[i].da);
      if (TBL[i].we) begin
        chk($sformatf("R10 vec%0d wdata", i), m_dd, TBL[i].wd);
        chk($sformatf("R10 vec%0d oe", i), m_oe, 1);
      end else begin
        chk($sformatf("R10 vec%0d rdata", i), m_rd, 16'hA500 + 16'(i));
        chk($sformatf("R10 vec%0d oe", i), m_oe, 0);
      end
    end

    // R1 disabled interface
    cfg = 16'h3301;
    idle_check("R1 disabled 1F0", 10'h1F0);
    idle_check("R1 disabled 3F6", 10'h3F6);

    // R2 out-of-window addresses
    cfg = 16'h8001;
    idle_check("R2 primary ignores 170", 10'h170);
    idle_check("R2 primary ignores 376", 10'h376);
    idle_check("R2 primary ignores 3F7", 10'h3F7);
    cfg = 16'hC001;
    idle_check("R2 secondary ignores 1F0", 10'h1F0);

    // R6 drive tracking: drive0 compatible, drive1 fast 2/1
    cfg = 16'hB310;
    run_cyc(1'b1, 10'h1F6, 16'h0010, 0);
    timing("R6 select write uses old drive", 8, 10);
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R6 drive1 fast", 2, 1);
    run_cyc(1'b1, 10'h3F6, 16'h0000, 0);
    timing("R6 control write", 2, 1);
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R6 control write keeps drive1", 2, 1);
    run_cyc(1'b1, 10'h1F6, 16'h0000, 0);
    timing("R6 back-select uses drive1", 2, 1);
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R6 drive0 compatible again", 8, 10);

    // R7 IORDY ignored when disabled
    cfg = 16'h8001; iordy = 1'b0;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R7 iordy disabled", 5, 4);

    // R5 compatible drive ignores IORDY even with enable bit set
    cfg = 16'h8002; iordy = 1'b0;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R5 compat ignores iordy", 8, 10);

    // R8 stretch until IORDY high
    cfg = 16'hA003; iordy = 1'b0; dd_in = 16'h7E57;
    run_cyc(1'b0, 10'h1F1, 16'h0000, 10);
    timing("R8 stretched", 10, 4);
    chk("R8 rdata", m_rd, 16'h7E57);
    chk("R8 no error", err, 0);

    // R9 IORDY released on the last wait clock wins
    cfg = 16'h8003; iordy = 1'b0;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 261);
    timing("R9 release at limit", 261, 4);
    chk("R9 no error at limit", err, 0);

    // R9 timeout
    iordy = 1'b0;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R9 timeout", 261, 4);
    chk("R9 error set", err, 1);
    cfg = 16'h8001;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R9 after timeout", 5, 4);
    chk("R9 error sticky", err, 1);

    // R11 reset clears error and drive select
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R11 error cleared", err, 0);
    chk("R11 bus idle", {cs0_n, cs1_n, dior_n, diow_n}, 4'hF);
    rst_n = 1'b1;
    cfg = 16'hB310;
    run_cyc(1'b0, 10'h1F0, 16'h0000, 0);
    timing("R6 reset selects drive0", 8, 10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule